// File: doc/BRIEF.md
# Smart Card Byte Transmitter with Automatic Resend

This block sends one byte at a time over a single shared open-drain line, in the style of a half-duplex smart card link. The host writes a byte into a holding register. The block then sends a frame made of a low start bit, the eight data bits least significant first, and an even parity bit. Two quiet bit periods follow. During that guard time the receiver may pull the line low to reject the frame.

A rejected frame sets a sticky error flag and is sent again from the holding register with no help from the host. The transmit-end flag stays low while resends are in progress. It rises, together with the data-empty flag, only after a frame is accepted. A programmable retry limit stops the resends. After the last permitted attempt the block goes quiet and waits until software clears the error flag and writes a new byte.

Top module: `sc_tx_retry`

## Requirements
- R1: After reset, `tdr_empty` and `tx_end` are 1, `err_flag` is 0 and `io_oe` is 0 (line released).
- R2: A write accepted while idle clears `tdr_empty` and `tx_end`. The start bit begins on the next cycle. Each bit lasts `bit_div` cycles, in this order: start (0), data bit 0 through bit 7, then a parity bit equal to the XOR of the eight data bits (even parity).
- R3: `io_oe` is 1 only while a 0 bit is on the line. It is 0 for 1 bits and for the whole two-bit guard time.
- R4: The line is sampled once per frame, in the cycle at offset 11*`bit_div` + `bit_div`/2 counted from the first start-bit cycle. A 0 there sets `err_flag` on the next cycle. `err_flag` then stays 1 until `err_clr`.
- R5: `err_irq` equals `err_flag` AND `err_ie`, and `tx_irq` equals `tx_end` AND `tx_ie`.
- R6: After a rejected frame, `tx_end` stays 0. If retries remain, the same byte starts again at offset 12*`bit_div`.
- R7: After an accepted frame, `tx_end` and `tdr_empty` both become 1, visible at offset 12*`bit_div`.
- R8: A write while a frame or resend is in progress is ignored. The byte being sent, and any later resend, keeps its original value.
- R9: After `retry_limit` resends have all been rejected, the block stops with the line released, `tx_end` = 0 and `tdr_empty` = 0. While `err_flag` is 1, writes are ignored. After `err_clr`, a write starts a new transmission.
- R10: `err_clr` clears `err_flag`. When `err_clr` falls in the same cycle as an error sample, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bit_div | input | DIVW | Clock cycles per bit (even, at least 4) |
| retry_limit | input | RTW | Maximum number of automatic resends |
| tx_ie | input | 1 | Transmit interrupt enable |
| err_ie | input | 1 | Error interrupt enable |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| err_clr | input | 1 | Clears the error flag |
| io_in | input | 1 | Sampled level of the shared line |
| io_oe | output | 1 | Drive line low when 1 |
| tdr_empty | output | 1 | Holding register may be written |
| tx_end | output | 1 | Last byte accepted by the receiver |
| err_flag | output | 1 | Sticky rejection flag |
| tx_irq | output | 1 | Transmit interrupt request |
| err_irq | output | 1 | Error interrupt request |

## Verification
Two events can land on the same cycle: a software clear of the error flag and the hardware setting of that flag by a rejected frame. The bench pulls the line low through the guard time and pulses `err_clr` exactly in the sample cycle. It then expects `err_flag` to read 1 at the end of the frame. A second collision is a host write that arrives while a frame is on the line. The bench places it in the middle of the start bit of a frame that will be rejected. It then checks every bit of both the current frame and the resend against the original byte.

// File: rtl/sc_tx_retry.sv
module sc_tx_retry #(
  parameter int DIVW = 8,
  parameter int RTW  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] bit_div,
  input  logic [RTW-1:0]  retry_limit,
  input  logic            tx_ie,
  input  logic            err_ie,
  input  logic            wr_en,
  input  logic [7:0]      wr_data,
  input  logic            err_clr,
  input  logic            io_in,
  output logic            io_oe,
  output logic            tdr_empty,
  output logic            tx_end,
  output logic            err_flag,
  output logic            tx_irq,
  output logic            err_irq
);

  localparam logic [3:0] FRAME_BITS = 4'd10;
  localparam logic [3:0] LAST_SLOT  = 4'd11;

  logic            busy, halted, nack;
  logic [7:0]      hold;
  logic [9:0]      sr;
  logic [3:0]      idx;
  logic [DIVW-1:0] cnt;
  logic [RTW-1:0]  tries;

  wire bit_end = (cnt == bit_div - 1'b1);
  wire last    = busy && (idx == LAST_SLOT) && bit_end;
  wire smp     = busy && (idx == LAST_SLOT) && (cnt == (bit_div >> 1));
  wire wr_ok   = wr_en && !busy && !(halted && err_flag);

  assign io_oe   = busy && (idx < FRAME_BITS) && !sr[0];
  assign tx_irq  = tx_end && tx_ie;
  assign err_irq = err_flag && err_ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      halted    <= 1'b0;
      nack      <= 1'b0;
      hold      <= '0;
      sr        <= '1;
      idx       <= '0;
      cnt       <= '0;
      tries     <= '0;
      tdr_empty <= 1'b1;
      tx_end    <= 1'b1;
      err_flag  <= 1'b0;
    end else begin
      if (err_clr) err_flag <= 1'b0;
      if (smp && !io_in) err_flag <= 1'b1;
      if (smp) nack <= !io_in;

      if (wr_ok) begin
        hold      <= wr_data;
        sr        <= {^wr_data, wr_data, 1'b0};
        busy      <= 1'b1;
        halted    <= 1'b0;
        nack      <= 1'b0;
        idx       <= '0;
        cnt       <= '0;
        tries     <= '0;
        tdr_empty <= 1'b0;
        tx_end    <= 1'b0;
      end else if (busy) begin
        if (!bit_end) begin
          cnt <= cnt + 1'b1;
        end else begin
          cnt <= '0;
          idx <= idx + 1'b1;
          sr  <= {1'b1, sr[9:1]};
          if (last) begin
            if (!nack) begin
              busy      <= 1'b0;
              tx_end    <= 1'b1;
              tdr_empty <= 1'b1;
            end else if (tries == retry_limit) begin
              busy   <= 1'b0;
              halted <= 1'b1;
            end else begin
              tries <= tries + 1'b1;
              idx   <= '0;
              sr    <= {^hold, hold, 1'b0};
              nack  <= 1'b0;
            end
          end
        end
      end
    end
  end

  // R3
  oe_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_oe |-> busy && idx < FRAME_BITS);

  // R2
  write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> !tdr_empty && !tx_end && busy);

  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !err_clr |=> err_flag);

  // R6
  no_end_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !tx_end);

  // R7
  end_with_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_end) |-> tdr_empty);

  // R8
  hold_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(hold));

  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !io_oe && !tx_end && !tdr_empty);

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp && !io_in |=> err_flag);

endmodule

// File: tb/sim_sc_tx_retry.sv
`timescale 1ns/1ps
module sim_sc_tx_retry;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bit_div = 8'd4;
  logic [2:0] retry_limit = 3'd0;
  logic       tx_ie = 1'b1, err_ie = 1'b1;
  logic       wr_en = 1'b0, err_clr = 1'b0, pull = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       io_oe, tdr_empty, tx_end, err_flag, tx_irq, err_irq;
  wire        io_in = ~(io_oe | pull);

  int tests = 0, fails = 0, div = 4;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sc_tx_retry u0 (
    .clk(clk), .rst_n(rst_n), .bit_div(bit_div), .retry_limit(retry_limit),
    .tx_ie(tx_ie), .err_ie(err_ie), .wr_en(wr_en), .wr_data(wr_data),
    .err_clr(err_clr), .io_in(io_in), .io_oe(io_oe), .tdr_empty(tdr_empty),
    .tx_end(tx_end), .err_flag(err_flag), .tx_irq(tx_irq), .err_irq(err_irq));

  task automatic chk(input string req, input int act, input int exp_v);
    tests++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic frame(input logic [7:0] exp, input bit nack, input bit clr_smp,
                       input bit poke, input bit pre_clr);
    int ones = 0;
    logic e;
    for (int i = 0; i < 8; i++) ones += int'(exp[i]);
    while (!io_oe) @(negedge clk);
    if (pre_clr) err_clr = 1'b1;
    repeat (div / 2) @(negedge clk);
    err_clr = 1'b0;
    for (int k = 0; k < 10; k++) begin
      e = (k == 0) ? 1'b0 : (k == 9) ? ones[0] : exp[k-1];
      chk("R2 frame bit", int'(io_in), int'(e));
      chk("R3 drive only low", int'(io_oe), int'(!e));
      if (k == 0 && poke) begin
        wr_en = 1'b1; wr_data = ~exp;
        @(negedge clk); wr_en = 1'b0;
        repeat (div - 1) @(negedge clk);
      end else begin
        repeat (div) @(negedge clk);
      end
    end
    chk("R3 guard released", int'(io_oe), 0);
    chk("R6 tx_end low in frame", int'(tx_end), 0);
    pull = nack;
    repeat (div) @(negedge clk);
    if (clr_smp) err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    @(negedge clk); pull = 1'b0;
    repeat (div / 2 - 2) @(negedge clk);
  endtask

  task automatic ok_flags(input string req);
    chk({req, " tx_end"}, int'(tx_end), 1);
    chk({req, " tdr_empty"}, int'(tdr_empty), 1);
    chk("R5 tx_irq", int'(tx_irq), int'(tx_ie));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tdr_empty", int'(tdr_empty), 1);
    chk("R1 tx_end", int'(tx_end), 1);
    chk("R1 err_flag", int'(err_flag), 0);
    chk("R1 io_oe", int'(io_oe), 0);

    // R2 R7: every byte value at the smallest divider
    div = 4; bit_div = 8'd4; retry_limit = 3'd2;
    for (int b = 0; b < 256; b++) begin
      tx_ie = b[0];
      write_byte(8'(b));
      frame(8'(b), 1'b0, 1'b0, 1'b0, 1'b0);
      ok_flags("R7");
      chk("R4 no error", int'(err_flag), 0);
    end
    tx_ie = 1'b1;

    // R2: several dividers
    for (int d = 6; d <= 12; d += 2) begin
      div = d; bit_div = 8'(d);
      for (int j = 0; j < 4; j++) begin
        write_byte(8'(d * 37 + j * 91));
        frame(8'(d * 37 + j * 91), 1'b0, 1'b0, 1'b0, 1'b0);
        ok_flags("R7 div");
      end
    end

    // R4 R5 R6 R7: k rejections then acceptance, within limit
    div = 6; bit_div = 8'd6;
    for (int L = 0; L < 4; L++) begin
      retry_limit = 3'(L);
      for (int k = 0; k <= L; k++) begin
        logic [7:0] b = 8'(8'h3C + L * 17 + k * 5);
        err_ie = k[0];
        write_byte(b);
        for (int j = 0; j < k; j++) begin
          frame(b, 1'b1, 1'b0, 1'b0, j > 0);
          chk("R6 tx_end held low", int'(tx_end), 0);
          chk("R6 tdr_empty low", int'(tdr_empty), 0);
          chk("R4 err set", int'(err_flag), 1);
          chk("R5 err_irq", int'(err_irq), int'(err_ie));
        end
        frame(b, 1'b0, 1'b0, 1'b0, k > 0);
        ok_flags("R7 after resend");
        chk("R10 err cleared", int'(err_flag), 0);
      end

      // R9: every attempt rejected
      begin
        logic [7:0] h = 8'(8'hC3 ^ L);
        int seen = 0;
        write_byte(h);
        for (int j = 0; j <= L; j++) frame(h, 1'b1, 1'b0, 1'b0, j > 0);
        chk("R9 halt tx_end", int'(tx_end), 0);
        chk("R9 halt tdr_empty", int'(tdr_empty), 0);
        chk("R9 err kept", int'(err_flag), 1);
        for (int c = 0; c < 3 * div; c++) begin @(negedge clk); seen |= int'(io_oe); end
        chk("R9 no further frame", seen, 0);
        write_byte(8'h55);
        for (int c = 0; c < 2 * div; c++) begin @(negedge clk); seen |= int'(io_oe); end
        chk("R9 write ignored while err", seen, 0);
        chk("R9 still not ended", int'(tx_end), 0);
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        chk("R10 clear", int'(err_flag), 0);
        write_byte(8'hA6);
        frame(8'hA6, 1'b0, 1'b0, 1'b0, 1'b0);
        ok_flags("R9 restart");
      end
    end

    // R10: clear in the sample cycle loses to the set
    retry_limit = 3'd3;
    write_byte(8'h9E);
    frame(8'h9E, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R10 set wins", int'(err_flag), 1);
    frame(8'h9E, 1'b0, 1'b0, 1'b0, 1'b1);
    ok_flags("R10 then ok");

    // R8: write during a frame that is then rejected
    retry_limit = 3'd1;
    write_byte(8'h2B);
    frame(8'h2B, 1'b1, 1'b0, 1'b1, 1'b0);
    frame(8'h2B, 1'b0, 1'b0, 1'b0, 1'b1);
    ok_flags("R8 original kept");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule